// File: doc/BRIEF.md
# Privilege and Illegal-Instruction Trap Unit

This unit sits between instruction decode and execution. For each instruction slot it decides whether the instruction may run, must be replaced by a program-interrupt trap, or stops the core. It looks at the opcode class, instruction bit 20, the decoder's illegal flag, the current instruction address and the 64-bit machine state. When a trap is taken it produces four values in the same cycle: the value for the saved-address register, the value for the saved-state register, the new machine state and the redirected next-instruction address.

The decision is combinational. The only storage is a sticky halted flag, which is set by the halt instruction. After that flag is set, no slot executes and no slot traps. When no trap occurs, the unit forwards either the sequential next address or a branch target supplied by the datapath.

Top module: `prog_trap_unit`

## Requirements
- R1: After reset, `halted` is 0. With `slot_valid` low, `trap_take` and `exec_en` are 0.
- R2: Opcode classes 1 (halt), 2 (read machine state), 3 (write machine state, 32-bit), 4 (write machine state, 64-bit) and 5 (return from interrupt) are always privileged.
- R3: Classes 6 (move to special register) and 7 (move from special register) are privileged only when `ibit20` is 1. With `ibit20` at 0 they run in problem state.
- R4: A privileged class in a valid slot while `state_in` bit 14 (problem state) is 1 raises a trap. The privileged-reason bit, `srr1_out` bit 18, is set.
- R5: A valid slot with `illegal_in` high raises a trap and sets the illegal-reason bit, `srr1_out` bit 19. Class 8 (condition-register field move) never takes this trap.
- R6: When a slot is both privileged-faulting and illegal, only the privileged reason is reported.
- R7: On a trap, `srr0_out` equals `cia`, `nia_out` equals 0x700 and `exec_en` is 0. Without a trap, `srr0_out` and `srr1_out` are 0.
- R8: On a trap, `srr1_out` equals `state_in` with the reason bit ORed in. `state_out` bits 18 and 19 are copied from `state_in`, so the reason bit never reaches the live state.
- R9: On a trap, `state_out` clears bits 1, 2, 4, 5, 8, 9, 10, 11, 13, 14, 15, 23, 25 and 32, sets bits 0 and 63, and keeps every other bit of `state_in`.
- R10: A halt in a valid slot with problem state 0 sets `halted` at the next clock edge. In that slot it does not execute, it ignores `illegal_in`, and it holds `nia_out` at `cia`. Once set, `halted` stays set: later slots neither execute nor trap, and `nia_out` equals `cia`.
- R11: A valid slot without a trap or halt has `exec_en` 1 and `state_out` equal to `state_in`. `nia_out` is `br_target` when `br_taken` is 1 and `cia`+4 otherwise.
- R12: With `slot_valid` low, nothing changes: `nia_out` equals `cia`, `state_out` equals `state_in`, and `halted` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_valid | input | 1 | An instruction is presented this cycle |
| op_class | input | 4 | Internal opcode class |
| ibit20 | input | 1 | Instruction bit 20 |
| illegal_in | input | 1 | The decoder reports the instruction as illegal |
| cia | input | 64 | Current instruction address |
| state_in | input | 64 | Live machine state |
| br_taken | input | 1 | The datapath redirects to `br_target` |
| br_target | input | 64 | Branch target address |
| exec_en | output | 1 | The instruction executes |
| trap_take | output | 1 | A program-interrupt trap is taken |
| srr0_out | output | 64 | Value for the saved-address register |
| srr1_out | output | 64 | Value for the saved-state register |
| state_out | output | 64 | Next machine state |
| nia_out | output | 64 | Next instruction address |
| halted | output | 1 | Sticky halted flag |

## Verification
Assertions check the following on every cycle:
- The halted flag stays set once it is set, and it is raised after a halt taken outside problem state.
- A halted or trapping slot never executes.
- Every trap clears problem state, sets the 64-bit-mode and little-endian bits, reports exactly one reason, and saves the current address.

The bench scenarios cover what the assertions do not:
- Which opcode classes are privileged under each value of bit 20.
- The priority of the privileged reason over the illegal reason, and the exemption of the field-move class.
- The exact forced-bit pattern on a state of all ones.
- Branch versus sequential next-address selection.
- Halt in problem state, which must trap rather than stop the core.

// File: rtl/prog_trap_unit.sv
module prog_trap_unit #(
  parameter logic [63:0] TRAP_VEC = 64'h700
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        slot_valid,
  input  logic [3:0]  op_class,
  input  logic        ibit20,
  input  logic        illegal_in,
  input  logic [63:0] cia,
  input  logic [63:0] state_in,
  input  logic        br_taken,
  input  logic [63:0] br_target,
  output logic        exec_en,
  output logic        trap_take,
  output logic [63:0] srr0_out,
  output logic [63:0] srr1_out,
  output logic [63:0] state_out,
  output logic [63:0] nia_out,
  output logic        halted
);
  localparam logic [3:0] OP_HALT = 4'd1, OP_RDST = 4'd2, OP_WRST32 = 4'd3,
                         OP_WRST64 = 4'd4, OP_RFI = 4'd5, OP_MTSR = 4'd6,
                         OP_MFSR = 4'd7, OP_CRFMV = 4'd8;
  localparam int B_LE = 0, B_RI = 1, B_PMM = 2, B_DR = 4, B_IR = 5,
                 B_FE1 = 8, B_TE0 = 9, B_TE1 = 10, B_FE0 = 11, B_FP = 13,
                 B_PR = 14, B_EE = 15, B_WHY_PRIV = 18, B_WHY_ILL = 19,
                 B_VSX = 23, B_VEC = 25, B_TM = 32, B_SF = 63;
  localparam logic [63:0] ONE = 64'd1;
  localparam logic [63:0] CLR_MASK =
      (ONE << B_RI) | (ONE << B_PMM) | (ONE << B_DR) | (ONE << B_IR) |
      (ONE << B_FE1) | (ONE << B_TE0) | (ONE << B_TE1) | (ONE << B_FE0) |
      (ONE << B_FP) | (ONE << B_PR) | (ONE << B_EE) | (ONE << B_VSX) |
      (ONE << B_VEC) | (ONE << B_TM);
  localparam logic [63:0] SET_MASK = (ONE << B_SF) | (ONE << B_LE);

  logic halted_q;
  logic live, always_priv, spr_priv, priv_trap, ill_trap, halt_go;

  assign live        = slot_valid && !halted_q;
  assign always_priv = (op_class == OP_HALT) || (op_class == OP_RDST) ||
                       (op_class == OP_WRST32) || (op_class == OP_WRST64) ||
                       (op_class == OP_RFI);
  assign spr_priv    = ((op_class == OP_MTSR) || (op_class == OP_MFSR)) && ibit20;
  assign priv_trap   = live && (always_priv || spr_priv) && state_in[B_PR];
  assign halt_go     = live && !priv_trap && (op_class == OP_HALT);
  assign ill_trap    = live && !priv_trap && !halt_go && illegal_in &&
                       (op_class != OP_CRFMV);

  assign trap_take = priv_trap || ill_trap;
  assign exec_en   = live && !trap_take && !halt_go;
  assign srr0_out  = trap_take ? cia : 64'd0;
  assign srr1_out  = !trap_take ? 64'd0 :
                     priv_trap ? (state_in | (ONE << B_WHY_PRIV))
                               : (state_in | (ONE << B_WHY_ILL));
  assign state_out = trap_take ? ((state_in & ~CLR_MASK) | SET_MASK) : state_in;
  assign nia_out   = trap_take ? TRAP_VEC :
                     exec_en   ? (br_taken ? br_target : cia + 64'd4) : cia;
  assign halted    = halted_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       halted_q <= 1'b0;
    else if (halt_go) halted_q <= 1'b1;
  end

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_valid && !halted && op_class == OP_HALT && !state_in[B_PR]) |=> halted);
  assert_halted_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!exec_en && !trap_take && nia_out == cia));
  assert_trap_no_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (!exec_en && srr0_out == cia && nia_out == TRAP_VEC));
  assert_forced_bits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> (!state_out[B_PR] && state_out[B_SF] && state_out[B_LE]));
  assert_one_reason_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |-> ($countones(srr1_out[B_WHY_ILL:B_WHY_PRIV] ^
                              state_in[B_WHY_ILL:B_WHY_PRIV]) <= 1 &&
                   srr1_out[B_WHY_ILL:B_WHY_PRIV] != 2'b00 &&
                   state_out[B_WHY_ILL:B_WHY_PRIV] == state_in[B_WHY_ILL:B_WHY_PRIV]));
  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_valid |-> (!exec_en && !trap_take && state_out == state_in));
endmodule

// File: tb/test_prog_trap_unit.sv
module test_prog_trap_unit;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        slot_valid = 1'b0, ibit20 = 1'b0, illegal_in = 1'b0, br_taken = 1'b0;
  logic [3:0]  op_class = 4'd0;
  logic [63:0] cia = 64'd0, state_in = 64'd0, br_target = 64'd0;
  logic        exec_en, trap_take, halted;
  logic [63:0] srr0_out, srr1_out, state_out, nia_out;

  int total = 0, bad = 0;
  bit done = 1'b0;
  bit m_halted = 1'b0;
  logic [63:0] clr_m, set_m;

  prog_trap_unit i_prog_trap_unit (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .op_class(op_class),
    .ibit20(ibit20), .illegal_in(illegal_in), .cia(cia), .state_in(state_in),
    .br_taken(br_taken), .br_target(br_target), .exec_en(exec_en),
    .trap_take(trap_take), .srr0_out(srr0_out), .srr1_out(srr1_out),
    .state_out(state_out), .nia_out(nia_out), .halted(halted));

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string req, input bit v, input logic [3:0] op, input bit b20,
                      input bit ill, input logic [63:0] a, input logic [63:0] st,
                      input bit bt, input logic [63:0] tgt);
    bit pr, priv, live, pt, it, hg, tr, ex;
    logic [63:0] e_nia, e_st, e_s1;
    @(negedge clk);
    slot_valid = v; op_class = op; ibit20 = b20; illegal_in = ill;
    cia = a; state_in = st; br_taken = bt; br_target = tgt;
    #1;
    pr   = st[14];
    priv = (op >= 4'd1 && op <= 4'd5) || ((op == 4'd6 || op == 4'd7) && b20);
    live = v && !m_halted;
    pt   = live && priv && pr;
    hg   = live && !pt && op == 4'd1;
    it   = live && !pt && !hg && ill && op != 4'd8;
    tr   = pt || it;
    ex   = live && !tr && !hg;
    e_st = tr ? ((st & ~clr_m) | set_m) : st;
    e_s1 = !tr ? 64'd0 : pt ? (st | (64'd1 << 18)) : (st | (64'd1 << 19));
    e_nia = tr ? 64'h700 : ex ? (bt ? tgt : a + 64'd4) : a;
    chk({req, " trap"}, {63'd0, trap_take}, {63'd0, tr});
    chk({req, " exec"}, {63'd0, exec_en}, {63'd0, ex});
    chk({req, " srr0"}, srr0_out, tr ? a : 64'd0);
    chk({req, " srr1"}, srr1_out, e_s1);
    chk({req, " state"}, state_out, e_st);
    chk({req, " nia"}, nia_out, e_nia);
    chk({req, " halted"}, {63'd0, halted}, {63'd0, m_halted});
    @(posedge clk);
    if (hg) m_halted = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] ps, sv;
    clr_m = 64'd0;
    foreach (clr_m[i]) if (i inside {1, 2, 4, 5, 8, 9, 10, 11, 13, 14, 15, 23, 25, 32}) clr_m[i] = 1'b1;
    set_m = (64'd1 << 63) | 64'd1;
    ps = 64'h0000_0000_0000_4000;
    sv = 64'h0000_0000_0000_0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 halted", {63'd0, halted}, 64'd0);
    chk("R1 trap", {63'd0, trap_take}, 64'd0);
    chk("R1 exec", {63'd0, exec_en}, 64'd0);
    rst_n = 1'b1;
    step("R11 seq", 1, 4'd0, 0, 0, 64'h1000, sv, 0, 64'h0);
    step("R11 branch", 1, 4'd0, 0, 0, 64'h1004, ps, 1, 64'h8000);
    step("R3 mtsr b20=0", 1, 4'd6, 0, 0, 64'h1008, ps, 0, 64'h0);
    step("R3 mfsr b20=0", 1, 4'd7, 0, 0, 64'h100c, ps, 0, 64'h0);
    step("R3 R4 mtsr b20=1", 1, 4'd6, 1, 0, 64'h1010, ps, 0, 64'h0);
    step("R3 R4 mfsr b20=1", 1, 4'd7, 1, 0, 64'h1014, ps | 64'hff, 0, 64'h0);
    step("R2 rdst sup", 1, 4'd2, 0, 0, 64'h1018, sv, 0, 64'h0);
    step("R2 rdst prob", 1, 4'd2, 0, 0, 64'h101c, ps, 0, 64'h0);
    step("R2 wrst32", 1, 4'd3, 0, 0, 64'h1020, ps, 0, 64'h0);
    step("R2 R9 wrst64 ones", 1, 4'd4, 0, 0, 64'h1024, '1, 0, 64'h0);
    step("R2 rfi", 1, 4'd5, 0, 0, 64'h1028, ps | (64'd1 << 19), 1, 64'h40);
    step("R5 R7 illegal", 1, 4'd0, 0, 1, 64'h2000, 64'h8000_0000_0000_a5a0, 0, 64'h0);
    step("R5 R8 illegal ones", 1, 4'd9, 0, 1, 64'h2004, ~ps, 0, 64'h0);
    step("R6 priority", 1, 4'd4, 0, 1, 64'h2008, ps, 0, 64'h0);
    step("R5 crf exempt", 1, 4'd8, 0, 1, 64'h200c, ps, 0, 64'h0);
    step("R10 halt prob traps", 1, 4'd1, 0, 0, 64'h2010, ps, 0, 64'h0);
    step("R12 idle", 0, 4'd4, 1, 1, 64'h2014, ps, 1, 64'h99);
    for (int k = 0; k < 80; k++) begin
      logic [3:0] op;
      logic [63:0] st;
      op = 4'($urandom % 10);
      st = {$urandom, $urandom};
      if (op == 4'd1) st[14] = 1'b1;
      step("R2 R3 R4 R5 R6 R8 R9 R11 mix", ($urandom % 5) != 0, op, $urandom % 2,
           ($urandom % 3) == 0, {$urandom, $urandom}, st, $urandom % 2, {$urandom, $urandom});
    end
    step("R10 halt", 1, 4'd1, 0, 1, 64'h3000, sv, 0, 64'h0);
    step("R10 after halt", 1, 4'd0, 0, 0, 64'h3004, sv, 1, 64'h50);
    step("R10 after halt illegal", 1, 4'd0, 0, 1, 64'h3008, sv, 0, 64'h0);
    step("R10 after halt priv", 1, 4'd4, 0, 0, 64'h300c, ps, 0, 64'h0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule